// File: doc/BRIEF.md
# Floating-point reciprocal exponent unit

This unit produces a coarse reciprocal estimate of a floating-point operand: the sign survives, the fraction is cleared, and the exponent becomes the bitwise inverse of the operand's exponent. A zero or subnormal operand gets a fixed exponent one step below the all-ones code. The estimate usually seeds an iterative division or reciprocal sequence. One unit handles half, single and double precision. A two-bit format input picks the precision, and the operand sits right-aligned on a 64-bit bus.

NaN operands follow the usual propagation rules. A signaling NaN raises the invalid-operation flag and comes back quieted. A quiet NaN passes through unchanged. With default-NaN mode on, every NaN is replaced by the format's canonical quiet NaN. The unit is a single registered stage. Three format lanes evaluate in parallel, and the format input chooses which lane loads the output register. There is no state machine, because nothing in the function needs sequencing: the result register is the only state.

Top module: `fp_recip_exp`

## Requirements
- R1: While the active-low reset is asserted, `res_out` and `inv_out` are zero.
- R2: The result and flag for the inputs present at a rising clock edge appear after that edge, and hold until the next edge.
- R3: For any non-NaN operand, the result carries the operand's sign and has an all-zero fraction field.
- R4: For a non-NaN operand with a nonzero exponent, the result exponent is the bitwise complement of the operand exponent within the format's exponent width. An infinity therefore gives a zero of the same sign.
- R5: For an operand whose exponent field is zero (zero or subnormal), the result exponent is all ones except its least significant bit: 0x1E for half, 0xFE for single, 0x7FE for double.
- R6: With default-NaN mode off, a NaN operand (exponent all ones, fraction nonzero) is returned with the same sign, exponent and fraction, except that the fraction's most significant bit is set.
- R7: `inv_out` is 1 exactly when the operand is a signaling NaN, meaning a NaN whose most significant fraction bit is 0. For every other operand it is 0, in either NaN mode.
- R8: With default-NaN mode on, any NaN operand returns a positive NaN with an all-ones exponent and only the most significant fraction bit set. The mode has no effect on non-NaN operands.
- R9: Format encoding: 00 is half (sign bit 15, exponent bits 14:10), 01 is single (sign bit 31, exponent bits 30:23), and 10 and 11 are both double (sign bit 63, exponent bits 62:52). Operand bits above the selected format's width are ignored, and the matching result bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_in | input | 64 | Operand, right-aligned for the chosen format |
| fmt_in | input | 2 | Format select (00 half, 01 single, 1x double) |
| dn_mode_in | input | 1 | Default-NaN mode |
| res_out | output | 64 | Registered estimate, zero-extended |
| inv_out | output | 1 | Registered invalid-operation flag |

## Verification
Both outputs are due exactly one rising edge after their operand, format and mode are applied. The bench drives each stimulus on a falling edge. It compares the outputs at the following falling edge, which is just after the register has loaded, and then drives the next stimulus in the same slot, so the pipeline never runs ahead of the checks. One directed check also samples the outputs just after an input change and before the next edge, to confirm they do not move early. The half-precision sweep covers every 16-bit pattern. The single and double sweeps walk every exponent code against fractions chosen to land in each class.

// File: rtl/frx_pkg.sv
package frx_pkg;
    localparam int XLEN  = 64;
    localparam int NLANE = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_DALIAS = 2'b11
    } frx_fmt_e;

    function automatic int lane_ew(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int lane_fw(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction
endpackage

// File: rtl/frx_classify.sv
module frx_classify #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = EW + FW + 1
) (
    input  logic [W-1:0]  val,
    output logic          sign,
    output logic [EW-1:0] expo,
    output logic [FW-1:0] frac,
    output logic          exp_zero,
    output logic          is_nan,
    output logic          is_snan
);
    logic exp_ones;

    always_comb begin
        sign     = val[W-1];
        expo     = val[FW +: EW];
        frac     = val[FW-1:0];
        exp_zero = (expo == '0);
        exp_ones = &expo;
        is_nan   = exp_ones && (frac != '0);
        is_snan  = is_nan && !frac[FW-1];
    end
endmodule

// File: rtl/frx_lane.sv
module frx_lane #(
    parameter int EW   = 8,
    parameter int FW   = 23,
    parameter int XLEN = 64,
    localparam int W   = EW + FW + 1
) (
    input  logic [W-1:0]    val,
    input  logic            dn_mode,
    output logic [XLEN-1:0] res,
    output logic            inv
);
    localparam logic [EW-1:0] EXP_ZERO_MAP = {{(EW-1){1'b1}}, 1'b0};
    localparam logic [FW-1:0] QUIET_BIT    = {1'b1, {(FW-1){1'b0}}};

    logic          sign;
    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          exp_zero;
    logic          is_nan;
    logic          is_snan;
    logic [W-1:0]  word;

    frx_classify #(.EW(EW), .FW(FW)) u_cls (
        .val     (val),
        .sign    (sign),
        .expo    (expo),
        .frac    (frac),
        .exp_zero(exp_zero),
        .is_nan  (is_nan),
        .is_snan (is_snan)
    );

    always_comb begin
        if (is_nan) begin
            if (dn_mode) word = {1'b0, {EW{1'b1}}, QUIET_BIT};
            else         word = {sign, expo, frac | QUIET_BIT};
        end else if (exp_zero) begin
            word = {sign, EXP_ZERO_MAP, {FW{1'b0}}};
        end else begin
            word = {sign, ~expo, {FW{1'b0}}};
        end
        res        = '0;
        res[W-1:0] = word;
        inv        = is_snan;
    end
endmodule

// File: rtl/fp_recip_exp.sv
module fp_recip_exp
    import frx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] op_in,
    input  logic [1:0]      fmt_in,
    input  logic            dn_mode_in,
    output logic [XLEN-1:0] res_out,
    output logic            inv_out
);
    logic [XLEN-1:0] lane_res [NLANE];
    logic            lane_inv [NLANE];
    logic [XLEN-1:0] nxt_res;
    logic            nxt_inv;
    frx_fmt_e        fmt;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int EW = lane_ew(g);
        localparam int FW = lane_fw(g);
        frx_lane #(.EW(EW), .FW(FW), .XLEN(XLEN)) u_lane (
            .val    (op_in[EW+FW:0]),
            .dn_mode(dn_mode_in),
            .res    (lane_res[g]),
            .inv    (lane_inv[g])
        );
    end

    always_comb begin
        fmt = frx_fmt_e'(fmt_in);
        unique case (fmt)
            FMT_HALF: begin
                nxt_res = lane_res[0];
                nxt_inv = lane_inv[0];
            end
            FMT_SINGLE: begin
                nxt_res = lane_res[1];
                nxt_inv = lane_inv[1];
            end
            FMT_DOUBLE, FMT_DALIAS: begin
                nxt_res = lane_res[2];
                nxt_inv = lane_inv[2];
            end
            default: begin
                nxt_res = '0;
                nxt_inv = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_out <= '0;
            inv_out <= 1'b0;
        end else begin
            res_out <= nxt_res;
            inv_out <= nxt_inv;
        end
    end
endmodule

// File: rtl/frx_chk.sv
module frx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_in,
    input logic [1:0]  fmt_in,
    input logic        dn_mode_in,
    input logic [63:0] res_out,
    input logic        inv_out
);
    logic [6:0]  ew, fw;
    logic [63:0] wmask, fmask, qbit, emax, expv, fracv, dnan;
    logic        c_nan, c_snan;

    always_comb begin
        case (fmt_in)
            2'b00:   begin ew = 7'd5;  fw = 7'd10; end
            2'b01:   begin ew = 7'd8;  fw = 7'd23; end
            default: begin ew = 7'd11; fw = 7'd52; end
        endcase
        wmask  = (ew + fw + 7'd1 == 7'd64) ? '1 : ((64'd1 << (ew + fw + 7'd1)) - 64'd1);
        fmask  = (64'd1 << fw) - 64'd1;
        qbit   = 64'd1 << (fw - 7'd1);
        emax   = (64'd1 << ew) - 64'd1;
        expv   = (op_in >> fw) & emax;
        fracv  = op_in & fmask;
        c_nan  = (expv == emax) && (fracv != 64'd0);
        c_snan = c_nan && ((fracv & qbit) == 64'd0);
        dnan   = (emax << fw) | qbit;
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!rst_n -> (res_out == 64'd0 && !inv_out)));

    a_r3_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !c_nan |=> ((res_out & $past(fmask)) == 64'd0));

    a_r6_quieted: assert property (@(posedge clk) disable iff (!rst_n)
        (c_nan && !dn_mode_in) |=> ((res_out & $past(qbit)) != 64'd0));

    a_r7_invalid_set: assert property (@(posedge clk) disable iff (!rst_n)
        c_snan |=> inv_out);

    a_r7_invalid_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !c_snan |=> !inv_out);

    a_r8_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (c_nan && dn_mode_in) |=> (res_out == $past(dnan)));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((res_out & ~$past(wmask)) == 64'd0));
endmodule

bind fp_recip_exp frx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_in     (op_in),
    .fmt_in    (fmt_in),
    .dn_mode_in(dn_mode_in),
    .res_out   (res_out),
    .inv_out   (inv_out)
);

// File: tb/fp_recip_exp_tb.sv
module fp_recip_exp_tb;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_in = '0;
    logic [1:0]  fmt_in = '0;
    logic        dn_mode_in = 1'b0;
    logic [63:0] res_out;
    logic        inv_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [63:0] exp_res_q;
    logic        exp_inv_q;
    string       tag_q;
    bit          pend = 0;

    always #(CLK_P/2) clk = ~clk;

    fp_recip_exp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_in     (op_in),
        .fmt_in    (fmt_in),
        .dn_mode_in(dn_mode_in),
        .res_out   (res_out),
        .inv_out   (inv_out)
    );

    task automatic model(input logic [63:0] op, input logic [1:0] f, input logic dn,
                         output logic [63:0] r, output logic iv, output string tg);
        int ew, fw;
        logic [63:0] emax, expv, fracv, qbit, sgn;
        if (f == 2'b00)      begin ew = 5;  fw = 10; end
        else if (f == 2'b01) begin ew = 8;  fw = 23; end
        else                 begin ew = 11; fw = 52; end
        emax  = (64'd1 << ew) - 64'd1;
        expv  = (op >> fw) & emax;
        fracv = op & ((64'd1 << fw) - 64'd1);
        qbit  = 64'd1 << (fw - 1);
        sgn   = ((op >> (ew + fw)) & 64'd1) << (ew + fw);
        iv    = 1'b0;
        if (expv == emax && fracv != 64'd0) begin
            iv = ((fracv & qbit) == 64'd0);
            if (dn) begin
                r = (emax << fw) | qbit;
                tg = "R8,R7";
            end else begin
                r = sgn | (expv << fw) | fracv | qbit;
                tg = iv ? "R6,R7" : "R6";
            end
        end else if (expv == 64'd0) begin
            r = sgn | ((emax - 64'd1) << fw);
            tg = "R3,R5,R7";
        end else begin
            r = sgn | ((emax - expv) << fw);
            tg = "R3,R4,R7";
        end
        if (f == 2'b11) tg = {tg, ",R9"};
    endtask

    task automatic compare(input logic [63:0] er, input logic ei, input string tg);
        compared++;
        if (res_out !== er || inv_out !== ei) begin
            mismatched++;
            $display("FAIL %s: res=%h inv=%b expected res=%h inv=%b", tg, res_out, inv_out, er, ei);
        end
    endtask

    task automatic step(input logic [63:0] op, input logic [1:0] f, input logic dn);
        logic [63:0] r;
        logic iv;
        string tg;
        @(negedge clk);
        if (pend) compare(exp_res_q, exp_inv_q, tag_q);
        op_in = op;
        fmt_in = f;
        dn_mode_in = dn;
        model(op, f, dn, r, iv, tg);
        exp_res_q = r;
        exp_inv_q = iv;
        tag_q = tg;
        pend = 1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero under reset, even with a live operand
        op_in = 64'h0000_0000_0000_7C01;
        repeat (3) @(negedge clk);
        compare(64'd0, 1'b0, "R1");
        rst_n = 1'b1;

        // R2: single 1.0 -> exponent 0x7F inverted to 0x80
        @(negedge clk);
        op_in = 64'h0000_0000_3F80_0000; fmt_in = 2'b01; dn_mode_in = 1'b0;
        @(negedge clk);
        compare(64'h0000_0000_4000_0000, 1'b0, "R2");
        op_in = 64'h0000_0000_7F80_0001;
        #1;
        compare(64'h0000_0000_4000_0000, 1'b0, "R2");

        // half: every 16-bit pattern, garbage above bit 15 (R9)
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] h;
            h = 16'(i);
            step({h ^ 16'h5A3C, ~h, h, h}, 2'b00, h[0] ^ h[7]);
        end

        // single: every exponent against class-picking fractions
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 4; k++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [22:0] fr;
                    case (k)
                        0: fr = 23'h0;
                        1: fr = 23'h1;
                        2: fr = 23'h400000;
                        default: fr = 23'h2AAAAA;
                    endcase
                    step({32'h5A5A_0F0F, k[0], 8'(e), fr}, 2'b01, d[0]);
                end
            end
        end

        // double: every exponent, zero / signaling / quiet fractions
        for (int e = 0; e < 2048; e++) begin
            for (int k = 0; k < 3; k++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [51:0] fr;
                    case (k)
                        0: fr = 52'h0;
                        1: fr = 52'h1;
                        default: fr = 52'h8_0000_0000_0000;
                    endcase
                    step({k[1] ^ d[0], 11'(e), fr}, 2'b10, d[0]);
                end
            end
        end

        // R9: format code 11 behaves as double
        for (int i = 0; i < 256; i++) begin
            logic [63:0] v;
            v = 64'(i) * 64'h9E37_79B9_7F4A_7C15;
            if (i % 8 == 0) v[62:52] = 11'h7FF;
            if (i % 8 == 1) v[62:52] = 11'h000;
            step(v, 2'b11, i[1]);
        end

        @(negedge clk);
        if (pend) compare(exp_res_q, exp_inv_q, tag_q);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule